// File: doc/BRIEF.md
# Repeat-Aware Corrected Error Counter

This block is one 64-bit syndrome register of an error-reporting node. It counts the corrected errors the node reports. Other severity classes are counted only when a build parameter enables them. In repeat mode the first countable error captures a syndrome tag, for example the cache set and way that failed. From then on, errors that carry the same tag advance a repeat counter and all other countable errors advance an other counter. Software can then tell one failing location apart from errors spread over many locations.

Each counter has a sticky wrap flag. The counters and flags survive an error-recovery reset, which only forgets the captured tag. Software reads and writes the whole word through a simple register port at the record's own address. While the node's status-valid flag is high, the captured tag is protected from writes. Without repeat mode the block holds a single counter.

Top module: `rcc_reg`

## Requirements
- R1: After the cold reset `rst_ni` is released, the register reads all zeros: counters, flags, tag and tag-valid.
- R2: The register is selected only when `reg_addr_i` equals 0x020 + 64 × `REC_IDX`. A read at any other address returns zero, and a write at any other address changes nothing.
- R3: `err_cls_i` encodes 0 = corrected, 1 = deferred, 2 = uncorrected, 3 = reserved. Corrected errors are always counted. Deferred errors are counted only if `COUNT_DEFER` is set, and uncorrected errors only if `COUNT_UNCORR` is set. Code 3 is never counted.
- R4: In repeat mode, a countable error that arrives while the tag is invalid does three things. It stores `err_tag_i` in bits [TAG_W-1:0], sets the valid bit at bit 31, and adds one to the repeat counter.
- R5: In repeat mode, a countable error with a valid tag adds one to the repeat counter when its tag equals the stored tag. Otherwise it adds one to the other counter. At most one counter changes per report.
- R6: The counter width CW is 15 when `WIDE` is 1 and 7 otherwise. The repeat (or single) count sits in bits [32+CW-1:32] with its flag at bit 32+CW. The other count sits in bits [33+2CW-1:33+CW] with its flag at bit 33+2CW.
- R7: When a counter advances from all ones to zero, its flag is set. The flag stays set through later increments until a register write changes it.
- R8: Without repeat mode, every countable error advances the single counter. All bits above its flag read zero, and so do bits [31:0].
- R9: While `rec_rst_i` is high, counters and flags are kept, the tag-valid bit is cleared, and error reports are ignored.
- R10: A register write loads both counters and both flags from the written data.
- R11: While `stat_mv_i` is 1, a write leaves the tag and the tag-valid bit unchanged but still loads the counters and flags. While `stat_mv_i` is 0, a write loads the tag and tag-valid bit as well.
- R12: When a write and a countable error meet in the same cycle, the written counter values are kept and that increment is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Cold reset, active low, asynchronous |
| rec_rst_i | input | 1 | Error-recovery reset, synchronous, active high |
| err_vld_i | input | 1 | Error report pulse |
| err_cls_i | input | 2 | Severity class of the report |
| err_tag_i | input | TAG_W | Syndrome tag of the report |
| stat_mv_i | input | 1 | Status-valid flag; protects the stored tag |
| reg_en_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Access is a write |
| reg_addr_i | input | ADDR_W | Byte address of the access |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data, valid in the cycle of a read access |

## Verification
The two functions that can fall in the same cycle are a software write and a counted error report. The bench drives both on one clock edge with a valid, matching tag. It then reads back the written count, and no increment may appear in it. It also reads the second record on the shared bus, which was not addressed, and that record must still have taken the increment. The same edge is also used to pair a recovery reset with an error report, and the judgement there is that the counts are unchanged and the tag is invalidated.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  typedef enum logic [1:0] {
    ECLS_CORR   = 2'd0,
    ECLS_DEFER  = 2'd1,
    ECLS_UNCORR = 2'd2,
    ECLS_RSVD   = 2'd3
  } err_cls_e;

  function automatic logic cls_countable(err_cls_e c, bit defer_en, bit uncorr_en);
    case (c)
      ECLS_CORR:   return 1'b1;
      ECLS_DEFER:  return defer_en;
      ECLS_UNCORR: return uncorr_en;
      default:     return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/rcc_route.sv
module rcc_route #(
  parameter bit REPEAT_EN    = 1'b1,
  parameter bit COUNT_DEFER  = 1'b1,
  parameter bit COUNT_UNCORR = 1'b0,
  parameter int TAG_W        = 16
) (
  input  logic             err_vld_i,
  input  logic [1:0]       err_cls_i,
  input  logic [TAG_W-1:0] err_tag_i,
  input  logic             block_i,
  input  logic             tag_vld_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             inc_rep_o,
  output logic             inc_oth_o,
  output logic             latch_o
);
  import rcc_pkg::*;

  logic cnt_ev;
  logic tag_hit;

  assign cnt_ev  = err_vld_i && !block_i &&
                   cls_countable(err_cls_e'(err_cls_i), COUNT_DEFER, COUNT_UNCORR);
  assign tag_hit = tag_vld_i && (tag_i == err_tag_i);

  generate
    if (REPEAT_EN) begin : g_rep
      assign latch_o   = cnt_ev && !tag_vld_i;
      assign inc_rep_o = cnt_ev && (!tag_vld_i || tag_hit);
      assign inc_oth_o = cnt_ev && tag_vld_i && !tag_hit;
    end else begin : g_single
      assign latch_o   = 1'b0;
      assign inc_rep_o = cnt_ev;
      assign inc_oth_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/rcc_ctr.sv
module rcc_ctr #(
  parameter int CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          wr_i,
  input  logic [CW-1:0] wr_cnt_i,
  input  logic          wr_of_i,
  output logic [CW-1:0] cnt_o,
  output logic          of_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      of_o  <= 1'b0;
    end else if (wr_i) begin
      cnt_o <= wr_cnt_i;
      of_o  <= wr_of_i;
    end else if (inc_i) begin
      cnt_o <= cnt_o + 1'b1;
      if (&cnt_o) of_o <= 1'b1;
    end
  end
endmodule

// File: rtl/rcc_tag.sv
module rcc_tag #(
  parameter int TAG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic             wr_vld_i,
  input  logic             latch_i,
  input  logic [TAG_W-1:0] err_tag_i,
  output logic [TAG_W-1:0] tag_o,
  output logic             vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_o <= '0;
      vld_o <= 1'b0;
    end else if (clr_i) begin
      vld_o <= 1'b0;
    end else if (wr_i) begin
      tag_o <= wr_tag_i;
      vld_o <= wr_vld_i;
    end else if (latch_i) begin
      tag_o <= err_tag_i;
      vld_o <= 1'b1;
    end
  end
endmodule

// File: rtl/rcc_reg.sv
module rcc_reg #(
  parameter bit REPEAT_EN    = 1'b1,
  parameter bit WIDE         = 1'b1,
  parameter bit COUNT_DEFER  = 1'b1,
  parameter bit COUNT_UNCORR = 1'b0,
  parameter int TAG_W        = 16,
  parameter int REC_IDX      = 0,
  parameter int ADDR_W       = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rec_rst_i,
  input  logic              err_vld_i,
  input  logic [1:0]        err_cls_i,
  input  logic [TAG_W-1:0]  err_tag_i,
  input  logic              stat_mv_i,
  input  logic              reg_en_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [63:0]       reg_wdata_i,
  output logic [63:0]       reg_rdata_o
);
  localparam int CW      = WIDE ? 15 : 7;
  localparam int REP_LSB = 32;
  localparam int REP_OF  = REP_LSB + CW;
  localparam int OTH_LSB = REP_OF + 1;
  localparam int OTH_OF  = OTH_LSB + CW;
  localparam int VLD_BIT = 31;
  localparam int BASE    = 'h20 + 64 * REC_IDX;

  logic              sel;
  logic              wr_hit;
  logic              inc_rep, inc_oth, latch;
  logic [CW-1:0]     rep_cnt, oth_cnt;
  logic              rep_of, oth_of;
  logic [TAG_W-1:0]  tag_q;
  logic              tag_vld_q;
  logic [63:0]       word;

  assign sel    = reg_en_i && (reg_addr_i == ADDR_W'(BASE));
  assign wr_hit = sel && reg_we_i;

  rcc_route #(
    .REPEAT_EN(REPEAT_EN), .COUNT_DEFER(COUNT_DEFER),
    .COUNT_UNCORR(COUNT_UNCORR), .TAG_W(TAG_W)
  ) i_route (
    .err_vld_i (err_vld_i),
    .err_cls_i (err_cls_i),
    .err_tag_i (err_tag_i),
    .block_i   (rec_rst_i),
    .tag_vld_i (tag_vld_q),
    .tag_i     (tag_q),
    .inc_rep_o (inc_rep),
    .inc_oth_o (inc_oth),
    .latch_o   (latch)
  );

  rcc_ctr #(.CW(CW)) i_rep_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (inc_rep),
    .wr_i     (wr_hit),
    .wr_cnt_i (reg_wdata_i[REP_LSB +: CW]),
    .wr_of_i  (reg_wdata_i[REP_OF]),
    .cnt_o    (rep_cnt),
    .of_o     (rep_of)
  );

  generate
    if (REPEAT_EN) begin : g_rep
      rcc_ctr #(.CW(CW)) i_oth_ctr (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .inc_i    (inc_oth),
        .wr_i     (wr_hit),
        .wr_cnt_i (reg_wdata_i[OTH_LSB +: CW]),
        .wr_of_i  (reg_wdata_i[OTH_OF]),
        .cnt_o    (oth_cnt),
        .of_o     (oth_of)
      );
      rcc_tag #(.TAG_W(TAG_W)) i_tag (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (rec_rst_i),
        .wr_i      (wr_hit && !stat_mv_i),
        .wr_tag_i  (reg_wdata_i[TAG_W-1:0]),
        .wr_vld_i  (reg_wdata_i[VLD_BIT]),
        .latch_i   (latch),
        .err_tag_i (err_tag_i),
        .tag_o     (tag_q),
        .vld_o     (tag_vld_q)
      );
    end else begin : g_single
      assign oth_cnt   = '0;
      assign oth_of    = 1'b0;
      assign tag_q     = '0;
      assign tag_vld_q = 1'b0;
    end
  endgenerate

  always_comb begin
    word                  = '0;
    word[REP_LSB +: CW]   = rep_cnt;
    word[REP_OF]          = rep_of;
    if (REPEAT_EN) begin
      word[OTH_LSB +: CW] = oth_cnt;
      word[OTH_OF]        = oth_of;
      word[TAG_W-1:0]     = tag_q;
      word[VLD_BIT]       = tag_vld_q;
    end
  end

  assign reg_rdata_o = (sel && !reg_we_i) ? word : 64'd0;
endmodule

// File: rtl/rcc_chk.sv
module rcc_chk #(
  parameter int CW    = 7,
  parameter int TAG_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rec_rst_i,
  input logic             err_vld_i,
  input logic             stat_mv_i,
  input logic             wr_hit,
  input logic [63:0]      reg_wdata_i,
  input logic [CW-1:0]    rep_cnt,
  input logic             rep_of,
  input logic [CW-1:0]    oth_cnt,
  input logic             oth_of,
  input logic [TAG_W-1:0] tag_q,
  input logic             tag_vld_q
);
  localparam logic [CW-1:0] MAXV = '1;

  // R1: cold reset holds everything cleared
  p_cold_clear_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (rep_cnt == '0 && oth_cnt == '0 && !rep_of && !oth_of && !tag_vld_q));

  // R7: flags are sticky without a write
  p_rep_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rep_of && !wr_hit) |=> rep_of);
  p_oth_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oth_of && !wr_hit) |=> oth_of);

  // R7: wrap through zero raises the flag
  p_rep_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_hit && rep_cnt == MAXV) |=> (rep_cnt == MAXV || rep_of));

  // R9: recovery reset keeps counts and drops the tag
  p_rec_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_rst_i && !wr_hit) |=> ($stable(rep_cnt) && $stable(oth_cnt) && !tag_vld_q));

  // R12: a write wins over a same-cycle increment
  p_write_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit |=> (rep_cnt == $past(reg_wdata_i[32 +: CW])));

  // R11: protected tag ignores writes
  p_mv_tag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && stat_mv_i && !err_vld_i && !rec_rst_i) |=> ($stable(tag_q) && $stable(tag_vld_q)));

  // R5: one report moves at most one counter
  p_one_inc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit |=> !(rep_cnt != $past(rep_cnt) && oth_cnt != $past(oth_cnt)));
endmodule

bind rcc_reg rcc_chk #(.CW(CW), .TAG_W(TAG_W)) i_rcc_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rec_rst_i   (rec_rst_i),
  .err_vld_i   (err_vld_i),
  .stat_mv_i   (stat_mv_i),
  .wr_hit      (wr_hit),
  .reg_wdata_i (reg_wdata_i),
  .rep_cnt     (rep_cnt),
  .rep_of      (rep_of),
  .oth_cnt     (oth_cnt),
  .oth_of      (oth_of),
  .tag_q       (tag_q),
  .tag_vld_q   (tag_vld_q)
);

// File: tb/test_rcc_reg.sv
`timescale 1ns/1ps
module test_rcc_reg;
  localparam logic [11:0] ADDR_A = 12'h0A0; // record 2, repeat mode
  localparam logic [11:0] ADDR_B = 12'h020; // record 0, single counter

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rec_rst = 1'b0;
  logic        err_vld = 1'b0;
  logic [1:0]  err_cls = 2'd0;
  logic [15:0] err_tag = '0;
  logic        stat_mv = 1'b0;
  logic        reg_en = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] rd_a, rd_b;

  int total = 0;
  int bad = 0;

  // models
  int         m_rep = 0, m_oth = 0, m_s = 0;
  bit         m_rof = 0, m_oof = 0, m_sof = 0, m_vld = 0;
  logic [15:0] m_tag = '0;

  always #4 clk = ~clk;

  rcc_reg #(.REPEAT_EN(1'b1), .WIDE(1'b0), .COUNT_DEFER(1'b1), .COUNT_UNCORR(1'b0),
            .TAG_W(16), .REC_IDX(2), .ADDR_W(12)) i_rcc_reg (
    .clk_i(clk), .rst_ni(rst_n), .rec_rst_i(rec_rst), .err_vld_i(err_vld),
    .err_cls_i(err_cls), .err_tag_i(err_tag), .stat_mv_i(stat_mv),
    .reg_en_i(reg_en), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(rd_a));

  rcc_reg #(.REPEAT_EN(1'b0), .WIDE(1'b0), .COUNT_DEFER(1'b1), .COUNT_UNCORR(1'b0),
            .TAG_W(16), .REC_IDX(0), .ADDR_W(12)) i_rcc_reg_single (
    .clk_i(clk), .rst_ni(rst_n), .rec_rst_i(rec_rst), .err_vld_i(err_vld),
    .err_cls_i(err_cls), .err_tag_i(err_tag), .stat_mv_i(stat_mv),
    .reg_en_i(reg_en), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(rd_b));

  function automatic logic [63:0] exp_a();
    logic [63:0] w = '0;
    w[38:32] = 7'(m_rep); w[39] = m_rof;
    w[46:40] = 7'(m_oth); w[47] = m_oof;
    w[15:0]  = m_tag;     w[31] = m_vld;
    return w;
  endfunction

  function automatic logic [63:0] exp_b();
    logic [63:0] w = '0;
    w[38:32] = 7'(m_s); w[39] = m_sof;
    return w;
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic rd(logic [11:0] a, output logic [63:0] va, output logic [63:0] vb);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1;
    va = rd_a; vb = rd_b;
    reg_en = 1'b0;
  endtask

  task automatic check_both(string req);
    logic [63:0] va, vb, d;
    rd(ADDR_A, va, d);
    check(req, va, exp_a());
    rd(ADDR_B, d, vb);
    check(req, vb, exp_b());
  endtask

  function automatic bit countable(logic [1:0] c);
    return (c == 2'd0) || (c == 2'd1);
  endfunction

  task automatic bump(inout int c, inout bit of);
    if (c == 127) of = 1'b1;
    c = (c + 1) % 128;
  endtask

  task automatic model_err(logic [1:0] c, logic [15:0] t, bit a_written);
    if (!countable(c)) return;
    bump(m_s, m_sof);
    if (a_written) return;
    if (!m_vld) begin
      m_vld = 1'b1; m_tag = t; bump(m_rep, m_rof);
    end else if (t == m_tag) bump(m_rep, m_rof);
    else bump(m_oth, m_oof);
  endtask

  task automatic model_wr_a(logic [63:0] d, bit mv);
    m_rep = int'(d[38:32]); m_rof = d[39];
    m_oth = int'(d[46:40]); m_oof = d[47];
    if (!mv) begin m_tag = d[15:0]; m_vld = d[31]; end
  endtask

  task automatic do_err(logic [1:0] c, logic [15:0] t);
    @(negedge clk);
    err_vld = 1'b1; err_cls = c; err_tag = t;
    @(negedge clk);
    err_vld = 1'b0;
    model_err(c, t, 1'b0);
  endtask

  task automatic do_wr(logic [11:0] a, logic [63:0] d, bit mv);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d; stat_mv = mv;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0; stat_mv = 1'b0;
    if (a == ADDR_A) model_wr_a(d, mv);
    if (a == ADDR_B) begin m_s = int'(d[38:32]); m_sof = d[39]; end
  endtask

  function automatic logic [63:0] word_a(int rep, bit rof, int oth, bit oof, logic [15:0] t, bit v);
    logic [63:0] w = '0;
    w[38:32] = 7'(rep); w[39] = rof; w[46:40] = 7'(oth); w[47] = oof;
    w[15:0] = t; w[31] = v;
    return w;
  endfunction

  initial begin
    #(8ns * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] va, vb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check_both("R1");

    // R4 first error latches tag and counts in repeat counter
    do_err(2'd0, 16'h1234);
    check_both("R4");
    rd(ADDR_A, va, vb);
    check("R4 tag", {32'd0, va[31], 15'd0, va[15:0]}, {32'd0, 1'b1, 15'd0, 16'h1234});

    // R5 matching vs non-matching, R3 classes, R8 single counter
    for (int i = 0; i < 48; i++) begin
      logic [1:0]  c = 2'(i % 4);
      logic [15:0] t = (i % 3 == 0) ? 16'h1234 : 16'(i);
      do_err(c, t);
      check_both("R5");
    end

    // R3 explicit: uncorrected and reserved are not counted
    do_err(2'd2, 16'h1234);
    check_both("R3 uncorr");
    do_err(2'd3, 16'h0042);
    check_both("R3 rsvd");

    // R6 field position check
    rd(ADDR_A, va, vb);
    check("R6 rep field", {57'd0, va[38:32]}, 64'(m_rep));
    check("R6 oth field", {57'd0, va[46:40]}, 64'(m_oth));

    // R10 write loads counters; then R7 wrap sweeps on both counters
    do_wr(ADDR_A, word_a(0, 0, 0, 0, 16'h1234, 1'b1), 1'b0);
    check_both("R10");
    for (int i = 0; i < 131; i++) begin
      do_err(2'd0, 16'h1234);
      rd(ADDR_A, va, vb);
      check("R7 rep wrap", va, exp_a());
    end
    for (int i = 0; i < 130; i++) begin
      do_err(2'd1, 16'hBEEF);
      rd(ADDR_A, va, vb);
      check("R7 oth wrap", va, exp_a());
    end
    check("R7 flags set", {62'd0, va[47], va[39]}, 64'd3);

    // R10 write clears flags and loads arbitrary counts
    do_wr(ADDR_A, word_a(99, 0, 17, 0, 16'h1234, 1'b1), 1'b0);
    check_both("R10 load");

    // R11 protected tag: tag ignored, counters still written
    do_wr(ADDR_A, word_a(5, 1, 6, 0, 16'hFFFF, 1'b0), 1'b1);
    check_both("R11 mv=1");
    do_wr(ADDR_A, word_a(5, 1, 6, 0, 16'h1234, 1'b1), 1'b0);
    check_both("R11 mv=0");

    // R12 same-cycle write and matching error: write wins in A, B still counts
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = ADDR_A;
    reg_wdata = word_a(40, 0, 3, 0, 16'h1234, 1'b1);
    err_vld = 1'b1; err_cls = 2'd0; err_tag = 16'h1234;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0; err_vld = 1'b0;
    model_wr_a(word_a(40, 0, 3, 0, 16'h1234, 1'b1), 1'b0);
    model_err(2'd0, 16'h1234, 1'b1);
    check_both("R12");

    // R9 recovery reset with concurrent error: counts kept, tag dropped
    @(negedge clk);
    rec_rst = 1'b1; err_vld = 1'b1; err_cls = 2'd0; err_tag = 16'h1234;
    @(negedge clk);
    rec_rst = 1'b0; err_vld = 1'b0;
    m_vld = 1'b0;
    check_both("R9 keep");
    do_err(2'd0, 16'h7777);
    check_both("R9 relatch");

    // R2 wrong address: write ignored, read returns zero
    do_wr(12'h0A8, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    check_both("R2 write");
    rd(12'h0A8, va, vb);
    check("R2 read", va | vb, 64'd0);

    // R8 single counter: write via its own address, upper and low bits zero
    do_wr(ADDR_B, 64'h0000_007E_0000_0000, 1'b0);
    do_err(2'd0, 16'h0001);
    do_err(2'd1, 16'h0002);
    check_both("R8");
    rd(ADDR_B, va, vb);
    check("R8 zero bits", {vb[63:40], vb[31:0]}, 56'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule